// File: doc/BRIEF.md
# Synchronous Burst SRAM with Burst Sequencer

This block is a synthesizable model of a single-ported synchronous static memory whose words are split into byte lanes. Each lane holds eight data bits and one parity bit, so the default word is 18 bits wide. Every control input is sampled on the rising clock edge. An access begins when one of two active-low address strobes captures an external address. The host-side strobe always starts a read. The controller-side strobe starts a read or a write, or it deselects the device. On later edges, an active-low advance input steps the two low address bits through a four-beat burst. The upper bits stay fixed for the whole burst. The burst order is linear or interleaved and is chosen by a mode pin.

The controller is a four-state machine. `ST_IDLE` means no access. `ST_READ` is a read burst, in which the word at the current burst address is presented. `ST_WRITE` is a write burst, in which each qualified edge stores input data at the current burst address. `ST_SLEEP` is standby. These are the transitions:
- Any state goes to `ST_SLEEP` on an edge where `sleep_i` is high.
- `ST_SLEEP` goes to `ST_IDLE` on the first edge where `sleep_i` is low.
- From `ST_IDLE`, `ST_READ` or `ST_WRITE`, a qualified host strobe goes to `ST_READ`.
- From those same states, a controller strobe goes to `ST_IDLE` (deselect), `ST_WRITE` or `ST_READ`.
- With no strobe, the state is held.

An active-low output enable gates the read data and the driver flag combinationally.

Top module: `sync_burst_sram`

## Requirements
- R1: After `rst_n` is asserted low, the block is in `ST_IDLE`, `drive_o` is 0 and `rdata_o` is all zeros.
- R2: On an edge with `cpu_stb_n`=0 and `ce_n`=0, the address on `addr_i` is captured and a read burst starts at beat 0. This holds regardless of `ctl_stb_n` and the write inputs. When `ce_n`=1 the host strobe is ignored, and an ongoing burst continues as if no strobe were present.
- R3: On an edge with `ctl_stb_n`=0, `ce_n`=0 and no qualified host strobe, the address is captured at beat 0. The burst is a write when `we_n`=0 and at least one bit of `lane_we_n` is 0; otherwise it is a read.
- R4: On an edge with `ctl_stb_n`=0 and `ce_n`=1, the block goes to `ST_IDLE`: `drive_o`=0 and `rdata_o`=0.
- R5: With `mode_i`=0 captured at the strobe, the low two address bits at beat k are (start + k) mod 4. The upper address bits equal those captured.
- R6: With `mode_i`=1 captured at the strobe, the low two address bits at beat k are start XOR k. The upper address bits equal those captured.
- R7: In a burst, an edge with `adv_n`=1 and no strobe leaves the beat unchanged. After beat 3 the beat does not advance until a new strobe.
- R8: In `ST_WRITE`, each edge with no strobe, `sleep_i`=0 and `we_n`=0 writes to the current burst address. It writes only the lanes whose `lane_we_n` bit is 0. Lane i occupies word bits [9i+8:9i]: data in the low 8 bits, parity in bit 9i+8. The beat then advances if `adv_n`=0. With `we_n`=1 nothing is written.
- R9: In `ST_READ`, once the edge has passed, `rdata_o` shows the stored word at the current burst address and `drive_o`=1 (given `oe_n`=0).
- R10: `oe_n`=1 forces `drive_o`=0 and `rdata_o`=0 combinationally, with no clock edge needed.
- R11: An edge with `sleep_i`=1 enters `ST_SLEEP`. On that edge strobes and writes are ignored and outputs are off. The first edge with `sleep_i`=0 returns to `ST_IDLE`.
- R12: A strobe during a burst abandons it and restarts at beat 0 from the new address.
- R13: The burst order is fixed by `mode_i` at the strobe. Changing `mode_i` mid-burst has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of controller and sequencer |
| addr_i | input | ADDR_W | External word address |
| cpu_stb_n | input | 1 | Host-side address strobe, active low, read only |
| ctl_stb_n | input | 1 | Controller-side address strobe, active low |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| we_n | input | 1 | Global write, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep_i | input | 1 | Standby request, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | LANES*(LANE_DATA_W+1) | Write word, parity included |
| rdata_o | output | LANES*(LANE_DATA_W+1) | Read word, zero when not driving |
| drive_o | output | 1 | High when read data is being driven |

## Verification
Two of the block's functions can fall on the same edge:
- A strobe and a burst step. The bench asserts a host strobe while the advance input is low and checks that the read data shows the new address at beat 0. It also holds the host strobe with chip enable off during an advance and checks that the next beat of the old burst appears.
- Both strobes at once, with the write controls active. The bench checks that the result is a read of the stored word and that the data presented on the following edge is not written.

Each sweep judges its outcome against a bench-side shadow memory that is updated from the stated address order.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } sb_state_e;

    localparam logic [1:0] SB_LAST_BEAT = 2'd3;

    // Low two address bits for a given start value and beat index.
    function automatic logic [1:0] sb_lo(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input logic       ilv);
        logic [1:0] r;
        if (ilv) r = start ^ beat;
        else     r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sram_burst_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             cpu_stb_n,
    input  logic             ctl_stb_n,
    input  logic             ce_n,
    input  logic             adv_n,
    input  logic             we_n,
    input  logic [LANES-1:0] lane_we_n,
    output sb_state_e        state_o,
    output logic             load_o,
    output logic             adv_en_o,
    output logic [LANES-1:0] lane_wr_o
);

    sb_state_e st_q;
    sb_state_e st_d;
    logic      cpu_go;
    logic      ctl_go;
    logic      any_stb;
    logic      wr_req;
    logic      in_burst;

    assign cpu_go  = !cpu_stb_n && !ce_n;
    assign ctl_go  = !ctl_stb_n;
    assign any_stb = cpu_go || ctl_go;
    assign wr_req  = !we_n && (lane_we_n != {LANES{1'b1}});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (sleep_i) begin
            st_d = ST_SLEEP;
        end else begin
            unique case (st_q)
                ST_SLEEP: st_d = ST_IDLE;
                ST_IDLE, ST_READ, ST_WRITE: begin
                    if (cpu_go) begin
                        st_d = ST_READ;
                    end else if (ctl_go) begin
                        if (ce_n)        st_d = ST_IDLE;
                        else if (wr_req) st_d = ST_WRITE;
                        else             st_d = ST_READ;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        in_burst  = ((st_q == ST_READ) || (st_q == ST_WRITE)) && !sleep_i && !any_stb;
        load_o    = !sleep_i && (st_q != ST_SLEEP) && (cpu_go || (ctl_go && !ce_n));
        adv_en_o  = in_burst && !adv_n;
        lane_wr_o = (in_burst && (st_q == ST_WRITE) && !we_n) ? ~lane_we_n : '0;
    end

    assign state_o = st_q;

endmodule

// File: rtl/sb_seq.sv
module sb_seq
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [1:0]        beat_o
);

    localparam int HI_W = ADDR_W - 2;

    logic [HI_W-1:0] hi_q;
    logic [1:0]      start_q;
    logic [1:0]      beat_q;
    logic            ilv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= 2'd0;
            beat_q  <= 2'd0;
            ilv_q   <= 1'b0;
        end else if (load_i) begin
            hi_q    <= addr_i[ADDR_W-1:2];
            start_q <= addr_i[1:0];
            beat_q  <= 2'd0;
            ilv_q   <= mode_i;
        end else if (adv_en_i && (beat_q != SB_LAST_BEAT)) begin
            beat_q  <= beat_q + 2'd1;
        end
    end

    assign cur_addr_o = {hi_q, sb_lo(start_q, beat_q, ilv_q)};
    assign beat_o     = beat_q;

endmodule

// File: rtl/sb_array.sv
module sb_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES-1:0]        lane_wr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_wr_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int LANE_DATA_W = 8,
    parameter int LANES       = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    addr_i,
    input  logic                                 cpu_stb_n,
    input  logic                                 ctl_stb_n,
    input  logic                                 ce_n,
    input  logic                                 adv_n,
    input  logic                                 we_n,
    input  logic [LANES-1:0]                     lane_we_n,
    input  logic                                 mode_i,
    input  logic                                 sleep_i,
    input  logic                                 oe_n,
    input  logic [LANES*(LANE_DATA_W+1)-1:0]     wdata_i,
    output logic [LANES*(LANE_DATA_W+1)-1:0]     rdata_o,
    output logic                                 drive_o
);

    localparam int LANE_W = LANE_DATA_W + 1;
    localparam int WORD_W = LANES * LANE_W;

    sb_state_e         state_w;
    logic              load_w;
    logic              adv_w;
    logic [LANES-1:0]  lwr_w;
    logic [ADDR_W-1:0] cur_w;
    logic [1:0]        beat_w;
    logic [WORD_W-1:0] rd_w;

    sb_ctrl #(.LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_i   (sleep_i),
        .cpu_stb_n (cpu_stb_n),
        .ctl_stb_n (ctl_stb_n),
        .ce_n      (ce_n),
        .adv_n     (adv_n),
        .we_n      (we_n),
        .lane_we_n (lane_we_n),
        .state_o   (state_w),
        .load_o    (load_w),
        .adv_en_o  (adv_w),
        .lane_wr_o (lwr_w)
    );

    sb_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_w),
        .adv_en_i   (adv_w),
        .addr_i     (addr_i),
        .mode_i     (mode_i),
        .cur_addr_o (cur_w),
        .beat_o     (beat_w)
    );

    sb_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .addr_i    (cur_w),
        .lane_wr_i (lwr_w),
        .wdata_i   (wdata_i),
        .rdata_o   (rd_w)
    );

    assign drive_o = !oe_n && (state_w == ST_READ);
    assign rdata_o = drive_o ? rd_w : '0;

endmodule

// File: rtl/sb_checker.sv
module sb_checker
    import sram_burst_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_i,
    input logic              cpu_stb_n,
    input logic              ctl_stb_n,
    input logic              ce_n,
    input logic              adv_n,
    input logic              oe_n,
    input logic              drive_o,
    input logic [WORD_W-1:0] rdata_o,
    input sb_state_e         state_i,
    input logic [1:0]        beat_i
);

    logic no_stb;
    assign no_stb = (cpu_stb_n || ce_n) && ctl_stb_n;

    a_r2_cpu_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && state_i != ST_SLEEP && !cpu_stb_n && !ce_n)
        |=> (state_i == ST_READ && beat_i == 2'd0));

    a_r4_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && state_i != ST_SLEEP && !ctl_stb_n && ce_n)
        |=> (state_i == ST_IDLE && !drive_o));

    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && no_stb && !adv_n && beat_i != 2'd3 &&
         (state_i == ST_READ || state_i == ST_WRITE))
        |=> (beat_i == $past(beat_i) + 2'd1));

    a_r7_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && no_stb && adv_n) |=> $stable(beat_i));

    a_r7_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i == 2'd3 && no_stb) |=> (beat_i == 2'd3));

    a_r10_oe: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!drive_o && rdata_o == '0));

    a_r11_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (state_i == ST_SLEEP && !drive_o));

endmodule

bind sync_burst_sram sb_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_i   (sleep_i),
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .ce_n      (ce_n),
    .adv_n     (adv_n),
    .oe_n      (oe_n),
    .drive_o   (drive_o),
    .rdata_o   (rdata_o),
    .state_i   (state_w),
    .beat_i    (beat_w)
);

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        cpu_n = 1'b1, ctl_n = 1'b1, ce_n = 1'b0, adv_n = 1'b1;
    logic        we_n = 1'b1, mode = 1'b0, sleep = 1'b0, oe_n = 1'b0;
    logic [1:0]  lane_n = 2'b11;
    logic [17:0] wdata = '0;
    logic [17:0] rdata;
    logic        drive;

    logic [17:0] shadow [256];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sync_burst_sram #(.ADDR_W(8), .LANE_DATA_W(8), .LANES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .cpu_stb_n(cpu_n),
        .ctl_stb_n(ctl_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
        .lane_we_n(lane_n), .mode_i(mode), .sleep_i(sleep), .oe_n(oe_n),
        .wdata_i(wdata), .rdata_o(rdata), .drive_o(drive)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] lo_of(input int s, input int k, input int m);
        return (m != 0) ? 2'((s ^ k) & 3) : 2'((s + k) & 3);
    endfunction

    function automatic logic [17:0] pat(input int hi, input int s, input int k,
                                        input int m, input int salt);
        int v;
        v = (hi * 40503 + s * 977 + k * 6151 + m * 13001 + salt * 24593 + 12345) * 3;
        return 18'(v);
    endfunction

    task automatic idle();
        cpu_n = 1'b1; ctl_n = 1'b1; we_n = 1'b1; lane_n = 2'b11;
        adv_n = 1'b1; sleep = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
    endtask

    task automatic write_burst(input int hi, input int s, input int m,
                               input logic [1:0] bwn, input int salt);
        logic [7:0] a;
        addr = {6'(hi), 2'(s)}; mode = m[0];
        ctl_n = 1'b0; we_n = 1'b0; lane_n = bwn;
        step();
        ctl_n = 1'b1; adv_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            a = {6'(hi), lo_of(s, k, m)};
            wdata = pat(hi, s, k, m, salt);
            step();
            for (int i = 0; i < 2; i++)
                if (!bwn[i]) shadow[a][i*9 +: 9] = wdata[i*9 +: 9];
        end
        idle();
    endtask

    task automatic read_one(input logic [7:0] a, input string req);
        addr = a; cpu_n = 1'b0;
        step();
        cpu_n = 1'b1;
        chk(req, rdata, shadow[a]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] a;
        int hv;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 drive", 18'(drive), 18'd0);
        chk("R1 rdata", rdata, 18'd0);
        rst_n = 1'b1;
        step();
        chk("R1 idle after release", 18'(drive), 18'd0);

        // R5 R6 R7 R8 R9: sweep over mode, start offset and upper bits
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int h = 0; h < 3; h++) begin
                    hv = (h == 0) ? 0 : ((h == 1) ? 21 : 63);
                    write_burst(hv, s, m, 2'b00, 0);
                    // single-address reads fix the write order per beat
                    for (int k = 0; k < 4; k++) begin
                        a = {6'(hv), lo_of(s, k, m)};
                        read_one(a, m ? "R6 order" : "R5 order");
                        chk("R8 stored word", shadow[a], pat(hv, s, k, m, 0));
                    end
                    // read burst with a wait on beat 1
                    addr = {6'(hv), 2'(s)}; mode = m[0]; cpu_n = 1'b0;
                    step();
                    cpu_n = 1'b1;
                    chk("R9 beat0", rdata, pat(hv, s, 0, m, 0));
                    chk("R9 drive", 18'(drive), 18'd1);
                    for (int k = 1; k < 4; k++) begin
                        adv_n = 1'b0;
                        step();
                        chk(m ? "R6 burst" : "R5 burst", rdata, pat(hv, s, k, m, 0));
                        if (k == 1) begin
                            adv_n = 1'b1;
                            step();
                            chk("R7 wait holds", rdata, pat(hv, s, 1, m, 0));
                        end
                    end
                    adv_n = 1'b0;
                    step();
                    chk("R7 saturate", rdata, pat(hv, s, 3, m, 0));
                    idle();
                end
            end
        end

        // R13: mode change mid-burst
        write_burst(10, 1, 0, 2'b00, 1);
        addr = {6'd10, 2'd1}; mode = 1'b0; cpu_n = 1'b0;
        step();
        cpu_n = 1'b1; mode = 1'b1; adv_n = 1'b0;
        for (int k = 1; k < 4; k++) begin
            step();
            chk("R13 order kept", rdata, shadow[{6'd10, lo_of(1, k, 0)}]);
        end
        idle();

        // R2: both strobes with write controls, host strobe wins
        addr = {6'd10, 2'd2}; mode = 1'b0;
        cpu_n = 1'b0; ctl_n = 1'b0; we_n = 1'b0; lane_n = 2'b00; wdata = 18'h2AAAA;
        step();
        chk("R2 priority read", rdata, shadow[{6'd10, 2'd2}]);
        chk("R2 priority drive", 18'(drive), 18'd1);
        cpu_n = 1'b1; ctl_n = 1'b1;
        step();
        chk("R2 no write in read", rdata, shadow[{6'd10, 2'd2}]);
        idle();

        // R3: controller read; R2: host strobe ignored with chip enable off
        addr = {6'd10, 2'd3}; ctl_n = 1'b0; mode = 1'b0;
        step();
        chk("R3 ctl read", rdata, shadow[{6'd10, 2'd3}]);
        ctl_n = 1'b1; cpu_n = 1'b0; ce_n = 1'b1; adv_n = 1'b0; addr = {6'd21, 2'd0};
        step();
        chk("R2 ignored when disabled", rdata, shadow[{6'd10, 2'd0}]);
        idle();

        // R4: deselect
        ctl_n = 1'b0; ce_n = 1'b1;
        step();
        chk("R4 drive off", 18'(drive), 18'd0);
        chk("R4 rdata zero", rdata, 18'd0);
        idle();

        // R8: byte lanes and global write off
        write_burst(20, 0, 0, 2'b00, 2);
        write_burst(20, 0, 0, 2'b10, 3);
        write_burst(20, 0, 0, 2'b01, 4);
        for (int k = 0; k < 4; k++)
            read_one({6'd20, 2'(k)}, "R8 lanes");
        addr = {6'd20, 2'd0}; ctl_n = 1'b0; we_n = 1'b0; lane_n = 2'b00;
        step();
        ctl_n = 1'b1; we_n = 1'b1; adv_n = 1'b0; wdata = 18'h00000;
        repeat (4) step();
        idle();
        for (int k = 0; k < 4; k++)
            read_one({6'd20, 2'(k)}, "R8 we_n high");

        // R10: asynchronous output enable
        read_one({6'd20, 2'd1}, "R9 before oe");
        oe_n = 1'b1;
        #1;
        chk("R10 drive off", 18'(drive), 18'd0);
        chk("R10 rdata zero", rdata, 18'd0);
        oe_n = 1'b0;
        #1;
        chk("R10 restored", rdata, shadow[{6'd20, 2'd1}]);
        idle();

        // R11: sleep blocks writes and strobes
        write_burst(30, 0, 0, 2'b00, 5);
        addr = {6'd30, 2'd0}; ctl_n = 1'b0; we_n = 1'b0; lane_n = 2'b00;
        step();
        ctl_n = 1'b1; sleep = 1'b1; adv_n = 1'b0; wdata = 18'h15555;
        step();
        chk("R11 sleep off", 18'(drive), 18'd0);
        cpu_n = 1'b0; we_n = 1'b1;
        step();
        chk("R11 strobe ignored", 18'(drive), 18'd0);
        sleep = 1'b0; cpu_n = 1'b1;
        step();
        chk("R11 wake idle", 18'(drive), 18'd0);
        idle();
        for (int k = 0; k < 4; k++)
            read_one({6'd30, 2'(k)}, "R11 no write");

        // R12: restart during burst
        addr = {6'd63, 2'd0}; mode = 1'b0; cpu_n = 1'b0;
        step();
        cpu_n = 1'b1; adv_n = 1'b0;
        step();
        step();
        chk("R12 mid burst", rdata, shadow[{6'd63, 2'd2}]);
        cpu_n = 1'b0; addr = {6'd10, 2'd1};
        step();
        chk("R12 restart beat0", rdata, shadow[{6'd10, 2'd1}]);
        cpu_n = 1'b1;
        step();
        chk("R12 restart beat1", rdata, shadow[{6'd10, 2'd2}]);
        idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule